// File: doc/BRIEF.md
# Multiplexed Memory Cycle Strobe Sequencer

This block is the bus-master side of a local-memory access. Each memory cycle takes eight equal sub-cycles. The block runs from a clock at twice the sub-cycle rate, so each cycle is sixteen clock ticks, numbered 0 to 15, and strobe edges can be placed to a half sub-cycle. During one cycle it drives three strobes: a row strobe (active low), a column strobe (active low) and an address-latch strobe (active high). It also drives two shared buses:

- a low bus, made of the low address byte plus extension bits, which carries the row address first and then the column address;
- a high bus, which carries the upper address first and then a status value.

A requester asks for an access by presenting the row, column, upper address, status, enable bits and the write flag, then raising the access request. A separate refresh request starts a refresh cycle. A refresh cycle runs the row strobe only and leaves every bus where it was. A request is taken only when the sequencer is idle or in the last tick of a cycle. The acknowledge outputs say which request was taken. Requests can follow each other with no idle tick between them. A one-tick done pulse marks the end of every cycle.

Top module: `memcyc_seq`

## Requirements
- R1: A cycle lasts 16 ticks. Tick 0 is the first clock after the request is taken. `done` is high on tick 15 only. On tick 15, `ras_n` has just risen: it is high on tick 12 and low on tick 11.
- R2: During any cycle, `ras_n` is low on ticks 3 to 11 (4.5 sub-cycles) and high on ticks 0 to 2 and 12 to 15 (3.5 sub-cycles).
- R3: In an access cycle, `bus_lo` shows the row address on ticks 0 to 4 and the column address from tick 5 on. The row is therefore valid 3 ticks before `ras_n` falls and held 2 ticks after it falls.
- R4: In an access cycle, `cas_n` is low on ticks 6 to 11 only. `bus_hi` shows the upper address on ticks 0 to 4 and the status value from tick 5 on. The column and status are therefore valid 1 tick before `cas_n` falls and held at least 2 ticks after it falls.
- R5: In an access cycle, `ale` is high on ticks 0 and 1 only.
- R6: `xen` and `wr` take the requested enable bits and write flag when an access is taken. They hold those values until the next access is taken.
- R7: In a refresh cycle, `ale` stays low and `cas_n` stays high. `bus_lo`, `bus_hi`, `xen` and `wr` keep the values they had before the refresh. When a refresh directly follows an access, `cas_n` is high for the 4 ticks between the two cycles.
- R8: A request raised on ticks 0 to 14 of a running cycle is neither acknowledged nor taken. The cycle runs to its end, and the sequencer then goes idle.
- R9: If both requests arrive in the same tick and `REFRESH_FIRST` is 1, the refresh is taken (`rfsh_ack` high, `acc_ack` low). If `REFRESH_FIRST` is 0, the access is taken.
- R10: After reset, and whenever the sequencer is idle, `ras_n` and `cas_n` are high and `ale` and `done` are low. Reset clears `bus_lo`, `bus_hi`, `xen` and `wr` to zero.
- R11: A request held during tick 15 is acknowledged there. Its tick 0 follows on the next clock, with no idle tick between the two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the sub-cycle rate |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_req | input | 1 | Access request |
| acc_wr | input | 1 | Write flag of the request |
| acc_row | input | LO_W+EXT_W | Row address |
| acc_col | input | LO_W+EXT_W | Column address |
| acc_upper | input | HI_W | Upper address shown during the latch phase |
| acc_status | input | HI_W | Status shown during the column phase |
| acc_xen | input | XEN_W | Extension enable bits |
| rfsh_req | input | 1 | Refresh request |
| acc_ack | output | 1 | Access request taken this tick |
| rfsh_ack | output | 1 | Refresh request taken this tick |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ale | output | 1 | Address-latch strobe, active high |
| bus_lo | output | LO_W+EXT_W | Low bus: row, then column |
| bus_hi | output | HI_W | High bus: upper address, then status |
| xen | output | XEN_W | Extension enable bits |
| wr | output | 1 | Write flag of the current access |
| done | output | 1 | High on the last tick of a cycle |

## Verification
The bench builds the block with `LO_W=4`, `EXT_W=1`, `HI_W=4` and `XEN_W=2`. At this size the low bus is five bits wide, so all 32 row codes can be swept in one chained run of access cycles, and every output is compared against arithmetic expectations on each of the 16 ticks. A second instance with `REFRESH_FIRST=0` shares the same inputs, which puts both priority variants within reach of a single collision. Further runs cover:
- a refresh placed directly after an access;
- a request poked in mid-cycle;
- the idle state after the last cycle.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

   typedef enum logic {
      CYC_ACCESS  = 1'b0,
      CYC_REFRESH = 1'b1
   } cyc_kind_e;

   localparam int TICKS_PER_SUB = 2;
   localparam int SUBS_PER_CYC  = 8;
   localparam int TICKS         = TICKS_PER_SUB * SUBS_PER_CYC;
   localparam int TICK_W        = $clog2(TICKS);

   localparam logic [TICK_W-1:0] T_LAST       = TICK_W'(TICKS - 1);
   localparam logic [TICK_W-1:0] T_LATCH_END  = TICK_W'(1 * TICKS_PER_SUB);
   localparam logic [TICK_W-1:0] T_RAS_FALL   = TICK_W'(3);
   localparam logic [TICK_W-1:0] T_RAS_RISE   = TICK_W'(12);
   localparam logic [TICK_W-1:0] T_COL_SWITCH = TICK_W'(5);
   localparam logic [TICK_W-1:0] T_CAS_FALL   = TICK_W'(6);
   localparam logic [TICK_W-1:0] T_CAS_RISE   = TICK_W'(12);

endpackage

// File: rtl/mseq_timer.sv
module mseq_timer
   import mseq_pkg::*;
#(
   parameter bit REFRESH_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_req,
   input  logic              rfsh_req,
   output logic              active_o,
   output cyc_kind_e         kind_o,
   output logic [TICK_W-1:0] tick_o,
   output logic              acc_take_o,
   output logic              rfsh_take_o
);

   logic              active_q;
   cyc_kind_e         kind_q;
   logic [TICK_W-1:0] tick_q;
   logic              window;

   // Requests are sampled only while idle or on the closing tick.
   assign window = !active_q || (tick_q == T_LAST);

   generate
      if (REFRESH_FIRST) begin : g_rfsh_first
         assign rfsh_take_o = window & rfsh_req;
         assign acc_take_o  = window & acc_req & ~rfsh_req;
      end else begin : g_acc_first
         assign acc_take_o  = window & acc_req;
         assign rfsh_take_o = window & rfsh_req & ~acc_req;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         kind_q   <= CYC_ACCESS;
         tick_q   <= '0;
      end else if (acc_take_o || rfsh_take_o) begin
         active_q <= 1'b1;
         kind_q   <= rfsh_take_o ? CYC_REFRESH : CYC_ACCESS;
         tick_q   <= '0;
      end else if (active_q) begin
         if (tick_q == T_LAST) begin
            active_q <= 1'b0;
            tick_q   <= '0;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   assign active_o = active_q;
   assign kind_o   = kind_q;
   assign tick_o   = tick_q;

   AST_NO_MIDCYCLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && tick_q != T_LAST) |=> (active_q && tick_q == $past(tick_q) + 1'b1)); // R8

endmodule

// File: rtl/mseq_strobe.sv
module mseq_strobe
   import mseq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  cyc_kind_e         kind_i,
   input  logic [TICK_W-1:0] tick_i,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              ale_o,
   output logic              done_o
);

   logic is_access;
   logic in_row;
   logic in_col;

   always_comb begin
      is_access = active_i && (kind_i == CYC_ACCESS);
      in_row    = active_i && (tick_i >= T_RAS_FALL) && (tick_i < T_RAS_RISE);
      in_col    = is_access && (tick_i >= T_CAS_FALL) && (tick_i < T_CAS_RISE);
      ras_n_o   = !in_row;
      cas_n_o   = !in_col;
      ale_o     = is_access && (tick_i < T_LATCH_END);
      done_o    = active_i && (tick_i == T_LAST);
   end

   AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n_o |-> !ras_n_o); // R4

   AST_ALE_TWO_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale_o) |=> ale_o ##1 !ale_o); // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R1

endmodule

// File: rtl/mseq_addr.sv
module mseq_addr
   import mseq_pkg::*;
#(
   parameter int LO_W  = 8,
   parameter int EXT_W = 2,
   parameter int HI_W  = 8,
   parameter int XEN_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc_take_i,
   input  logic                   active_i,
   input  cyc_kind_e              kind_i,
   input  logic [TICK_W-1:0]      tick_i,
   input  logic [LO_W+EXT_W-1:0]  row_i,
   input  logic [LO_W+EXT_W-1:0]  col_i,
   input  logic [HI_W-1:0]        upper_i,
   input  logic [HI_W-1:0]        status_i,
   input  logic [XEN_W-1:0]       xen_i,
   input  logic                   wr_i,
   output logic [LO_W+EXT_W-1:0]  bus_lo_o,
   output logic [HI_W-1:0]        bus_hi_o,
   output logic [XEN_W-1:0]       xen_o,
   output logic                   wr_o
);

   localparam int AW = LO_W + EXT_W;
   localparam logic [TICK_W-1:0] T_PRE_SWITCH = T_COL_SWITCH - 1'b1;

   logic [AW-1:0]    row_q;
   logic [AW-1:0]    col_q;
   logic [HI_W-1:0]  upper_q;
   logic [HI_W-1:0]  status_q;
   logic [XEN_W-1:0] xen_q;
   logic             wr_q;
   logic             show_col_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q      <= '0;
         col_q      <= '0;
         upper_q    <= '0;
         status_q   <= '0;
         xen_q      <= '0;
         wr_q       <= 1'b0;
         show_col_q <= 1'b0;
      end else if (acc_take_i) begin
         row_q      <= row_i;
         col_q      <= col_i;
         upper_q    <= upper_i;
         status_q   <= status_i;
         xen_q      <= xen_i;
         wr_q       <= wr_i;
         show_col_q <= 1'b0;
      end else if (active_i && kind_i == CYC_ACCESS && tick_i == T_PRE_SWITCH) begin
         show_col_q <= 1'b1;
      end
   end

   assign bus_lo_o = show_col_q ? col_q    : row_q;
   assign bus_hi_o = show_col_q ? status_q : upper_q;
   assign xen_o    = xen_q;
   assign wr_o     = wr_q;

   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(acc_take_i) |-> ($stable(xen_o) && $stable(wr_o))); // R6

endmodule

// File: rtl/memcyc_seq.sv
module memcyc_seq
   import mseq_pkg::*;
#(
   parameter int LO_W          = 8,
   parameter int EXT_W         = 2,
   parameter int HI_W          = 8,
   parameter int XEN_W         = 2,
   parameter bit REFRESH_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_req,
   input  logic                  acc_wr,
   input  logic [LO_W+EXT_W-1:0] acc_row,
   input  logic [LO_W+EXT_W-1:0] acc_col,
   input  logic [HI_W-1:0]       acc_upper,
   input  logic [HI_W-1:0]       acc_status,
   input  logic [XEN_W-1:0]      acc_xen,
   input  logic                  rfsh_req,
   output logic                  acc_ack,
   output logic                  rfsh_ack,
   output logic                  ras_n,
   output logic                  cas_n,
   output logic                  ale,
   output logic [LO_W+EXT_W-1:0] bus_lo,
   output logic [HI_W-1:0]       bus_hi,
   output logic [XEN_W-1:0]      xen,
   output logic                  wr,
   output logic                  done
);

   generate
      if (LO_W < 1 || EXT_W < 0 || HI_W < 1 || XEN_W < 1) begin : g_bad_cfg
         $error("memcyc_seq: bus widths out of range");
      end
      if (TICKS != 16) begin : g_bad_grid
         $error("memcyc_seq: strobe grid assumes sixteen ticks per cycle");
      end
   endgenerate

   logic              active;
   cyc_kind_e         kind;
   logic [TICK_W-1:0] tick;

   mseq_timer #(
      .REFRESH_FIRST (REFRESH_FIRST)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_req     (acc_req),
      .rfsh_req    (rfsh_req),
      .active_o    (active),
      .kind_o      (kind),
      .tick_o      (tick),
      .acc_take_o  (acc_ack),
      .rfsh_take_o (rfsh_ack)
   );

   mseq_strobe u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .kind_i   (kind),
      .tick_i   (tick),
      .ras_n_o  (ras_n),
      .cas_n_o  (cas_n),
      .ale_o    (ale),
      .done_o   (done)
   );

   mseq_addr #(
      .LO_W  (LO_W),
      .EXT_W (EXT_W),
      .HI_W  (HI_W),
      .XEN_W (XEN_W)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_take_i (acc_ack),
      .active_i   (active),
      .kind_i     (kind),
      .tick_i     (tick),
      .row_i      (acc_row),
      .col_i      (acc_col),
      .upper_i    (acc_upper),
      .status_i   (acc_status),
      .xen_i      (acc_xen),
      .wr_i       (acc_wr),
      .bus_lo_o   (bus_lo),
      .bus_hi_o   (bus_hi),
      .xen_o      (xen),
      .wr_o       (wr)
   );

   AST_RAS_LOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> ($past(ras_n, 9) == 1'b0 && $past(ras_n, 10) == 1'b1)); // R2

   AST_DONE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(ras_n, 4) == 1'b0 && $past(ras_n, 3) == 1'b1)); // R1

   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> $stable(bus_lo) ##1 $stable(bus_lo)); // R3

   AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> ($stable(bus_lo) && $stable(bus_hi))
                       ##1 ($stable(bus_lo) && $stable(bus_hi))); // R4

   AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_ack |=> (!ale && $stable(bus_lo) && $stable(bus_hi))); // R7

endmodule

// File: tb/tb_memcyc_seq.sv
`timescale 1ns/1ps
module tb_memcyc_seq;

   localparam int LO_W  = 4;
   localparam int EXT_W = 1;
   localparam int HI_W  = 4;
   localparam int XEN_W = 2;
   localparam int AW    = LO_W + EXT_W;

   logic clk = 1'b0;
   logic rst_n;
   logic acc_req, acc_wr, rfsh_req;
   logic [AW-1:0]    acc_row, acc_col;
   logic [HI_W-1:0]  acc_upper, acc_status;
   logic [XEN_W-1:0] acc_xen;

   logic acc_ack, rfsh_ack, ras_n, cas_n, ale, wr, done;
   logic [AW-1:0]    bus_lo;
   logic [HI_W-1:0]  bus_hi;
   logic [XEN_W-1:0] xen;

   logic b_acc_ack, b_rfsh_ack, b_ras_n, b_cas_n, b_ale, b_wr, b_done;
   logic [AW-1:0]    b_bus_lo;
   logic [HI_W-1:0]  b_bus_hi;
   logic [XEN_W-1:0] b_xen;

   always #10 clk = ~clk;

   memcyc_seq #(.LO_W(LO_W), .EXT_W(EXT_W), .HI_W(HI_W), .XEN_W(XEN_W), .REFRESH_FIRST(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr), .acc_row(acc_row),
      .acc_col(acc_col), .acc_upper(acc_upper), .acc_status(acc_status), .acc_xen(acc_xen),
      .rfsh_req(rfsh_req), .acc_ack(acc_ack), .rfsh_ack(rfsh_ack), .ras_n(ras_n),
      .cas_n(cas_n), .ale(ale), .bus_lo(bus_lo), .bus_hi(bus_hi), .xen(xen), .wr(wr),
      .done(done));

   memcyc_seq #(.LO_W(LO_W), .EXT_W(EXT_W), .HI_W(HI_W), .XEN_W(XEN_W), .REFRESH_FIRST(1'b0)) dut_b (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr), .acc_row(acc_row),
      .acc_col(acc_col), .acc_upper(acc_upper), .acc_status(acc_status), .acc_xen(acc_xen),
      .rfsh_req(rfsh_req), .acc_ack(b_acc_ack), .rfsh_ack(b_rfsh_ack), .ras_n(b_ras_n),
      .cas_n(b_cas_n), .ale(b_ale), .bus_lo(b_bus_lo), .bus_hi(b_bus_hi), .xen(b_xen),
      .wr(b_wr), .done(b_done));

   int n_chk = 0;
   int n_bad = 0;

   // current access data and values held on the buses
   logic [AW-1:0]    c_row, c_col, h_lo;
   logic [HI_W-1:0]  c_up, c_st, h_hi;
   logic [XEN_W-1:0] c_xen, h_xen;
   logic             c_wr, h_wr;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic put_req(input bit is_ref, input logic [AW-1:0] r, input logic [AW-1:0] c,
                          input logic [HI_W-1:0] u, input logic [HI_W-1:0] s,
                          input logic [XEN_W-1:0] x, input bit w);
      if (is_ref) rfsh_req = 1'b1;
      else begin
         acc_req = 1'b1; acc_row = r; acc_col = c; acc_upper = u;
         acc_status = s; acc_xen = x; acc_wr = w;
      end
   endtask

   task automatic chk_idle(input string req);
      chk(req, "idle ras_n", ras_n, 1);
      chk(req, "idle cas_n", cas_n, 1);
      chk(req, "idle ale", ale, 0);
      chk(req, "idle done", done, 0);
   endtask

   // called at a negedge from idle: request, check ack, move to tick 0
   task automatic start(input bit is_ref, input logic [AW-1:0] r, input logic [AW-1:0] c,
                        input logic [HI_W-1:0] u, input logic [HI_W-1:0] s,
                        input logic [XEN_W-1:0] x, input bit w);
      put_req(is_ref, r, c, u, s, x, w);
      #1;
      if (is_ref) chk("R7", "rfsh_ack", rfsh_ack, 1);
      else begin
         chk("R6", "acc_ack", acc_ack, 1);
         c_row = r; c_col = c; c_up = u; c_st = s; c_xen = x; c_wr = w;
      end
      @(negedge clk);
   endtask

   // entered at the negedge of tick 0; leaves at the negedge after tick 15
   task automatic run_cycle(input bit is_ref, input bit poke, input bit chain, input bit nref,
                            input logic [AW-1:0] nr, input logic [AW-1:0] nc,
                            input logic [HI_W-1:0] nu, input logic [HI_W-1:0] ns,
                            input logic [XEN_W-1:0] nx, input bit nw);
      for (int t = 0; t < 16; t++) begin
         chk("R2", $sformatf("ras_n t%0d", t), ras_n, (t >= 3 && t <= 11) ? 0 : 1);
         chk("R1", $sformatf("done t%0d", t), done, (t == 15) ? 1 : 0);
         if (is_ref) begin
            chk("R7", $sformatf("ale t%0d", t), ale, 0);
            chk("R7", $sformatf("cas_n t%0d", t), cas_n, 1);
            chk("R7", $sformatf("bus_lo t%0d", t), bus_lo, h_lo);
            chk("R7", $sformatf("bus_hi t%0d", t), bus_hi, h_hi);
            chk("R7", $sformatf("xen t%0d", t), xen, h_xen);
            chk("R7", $sformatf("wr t%0d", t), wr, h_wr);
         end else begin
            chk("R5", $sformatf("ale t%0d", t), ale, (t < 2) ? 1 : 0);
            chk("R4", $sformatf("cas_n t%0d", t), cas_n, (t >= 6 && t <= 11) ? 0 : 1);
            chk("R3", $sformatf("bus_lo t%0d", t), bus_lo, (t < 5) ? c_row : c_col);
            chk("R4", $sformatf("bus_hi t%0d", t), bus_hi, (t < 5) ? c_up : c_st);
            chk("R6", $sformatf("xen t%0d", t), xen, c_xen);
            chk("R6", $sformatf("wr t%0d", t), wr, c_wr);
         end
         if (t == 0) begin
            acc_req = 1'b0; rfsh_req = 1'b0;
         end
         if (poke && t == 7) begin
            put_req(1'b0, ~c_row, ~c_col, ~c_up, ~c_st, ~c_xen, ~c_wr);
            #1 chk("R8", "mid-cycle acc_ack", acc_ack, 0);
         end
         if (poke && t == 8) acc_req = 1'b0;
         if (t == 15 && chain) begin
            put_req(nref, nr, nc, nu, ns, nx, nw);
            #1;
            if (nref) chk("R11", "chained rfsh_ack", rfsh_ack, 1);
            else chk("R11", "chained acc_ack", acc_ack, 1);
         end
         @(negedge clk);
      end
      if (!is_ref) begin
         h_lo = c_col; h_hi = c_st; h_xen = c_xen; h_wr = c_wr;
      end
      if (chain && !nref) begin
         c_row = nr; c_col = nc; c_up = nu; c_st = ns; c_xen = nx; c_wr = nw;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; acc_req = 1'b0; rfsh_req = 1'b0; acc_wr = 1'b0;
      acc_row = '0; acc_col = '0; acc_upper = '0; acc_status = '0; acc_xen = '0;
      h_lo = '0; h_hi = '0; h_xen = '0; h_wr = 1'b0;
      c_row = '0; c_col = '0; c_up = '0; c_st = '0; c_xen = '0; c_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R10");
      chk("R10", "reset bus_lo", bus_lo, 0);
      chk("R10", "reset bus_hi", bus_hi, 0);
      chk("R10", "reset xen", xen, 0);
      chk("R10", "reset wr", wr, 0);

      // chained sweep over every row code (R11 back-to-back)
      start(1'b0, 5'd0, ~5'd0, 4'hA, 4'd1, 2'd0, 1'b0);
      for (int v = 0; v < 32; v++) begin
         logic [AW-1:0] n = AW'(v + 1);
         run_cycle(1'b0, 1'b0, v < 31, 1'b0, n, ~n, n[3:0] ^ 4'hA,
                   4'(n[4:1] + 4'd1), n[1:0], n[2]);
      end
      chk_idle("R11");

      // lone refresh keeps the buses
      start(1'b1, '0, '0, '0, '0, '0, 1'b0);
      run_cycle(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0, 1'b0);
      chk_idle("R7");

      // mid-cycle request is ignored
      start(1'b0, 5'h15, 5'h0A, 4'h3, 4'hC, 2'd2, 1'b1);
      run_cycle(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, '0, '0, '0, 1'b0);
      for (int k = 0; k < 4; k++) begin
         chk_idle("R8");
         chk("R8", "poke not latched bus_lo", bus_lo, 5'h0A);
         @(negedge clk);
      end

      // refresh right after an access
      start(1'b0, 5'h09, 5'h16, 4'h5, 4'h6, 2'd1, 1'b0);
      run_cycle(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, '0, '0, '0, 1'b0);
      run_cycle(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0, 1'b0);
      chk_idle("R7");

      // simultaneous requests: priority variants
      put_req(1'b0, 5'h1F, 5'h01, 4'h7, 4'h8, 2'd3, 1'b1);
      rfsh_req = 1'b1;
      #1;
      chk("R9", "refresh-first rfsh_ack", rfsh_ack, 1);
      chk("R9", "refresh-first acc_ack", acc_ack, 0);
      chk("R9", "access-first acc_ack", b_acc_ack, 1);
      chk("R9", "access-first rfsh_ack", b_rfsh_ack, 0);
      @(negedge clk);
      chk("R9", "access-first ale t0", b_ale, 1);
      chk("R9", "access-first bus_lo t0", b_bus_lo, 5'h1F);
      chk("R9", "refresh-first ale t0", ale, 0);
      run_cycle(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0, 1'b0);
      chk_idle("R10");

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule